// File: doc/BRIEF.md
# Bandwidth-Quantum Channel Arbiter

This block shares one data mover among four DMA channels. Each channel holds its request line high while it has work pending. The arbiter grants exactly one channel at a time. While a channel holds the grant, the arbiter adds up the bytes that the mover reports on each beat. A channel may keep the grant across several back-to-back transfers of a chain until its bandwidth quantum is spent. At that point the arbiter looks for the next requesting channel in rotating order. If no other channel wants the mover, the owner keeps it and its byte count starts again from zero.

Each channel has its own quantum register, 16 bits wide, in bytes. It is set through a small write port. Reset, or a write of zero, loads 1024. The granted index, a grant-valid flag and a one-cycle switch pulse come from registers. A decision taken on a clock edge therefore shows on the outputs straight after that edge.

Top module: `qchan_arbiter`

## Requirements
- R1: After reset, gnt_valid_o is 0, gnt_idx_o is 0 and switch_o is 0. Every channel's quantum is 1024 bytes: with no configuration written, a single requester keeps the grant through 1023 counted bytes and loses it on the beat that reaches 1024, if another channel is requesting.
- R2: Channel i requests through bit i of req_i. gnt_idx_o is the binary channel number. At most one channel is granted. A new grant goes only to a channel whose request bit was 1 at the deciding edge, and it appears on the outputs right after that edge.
- R3: While the owner keeps requesting and its counted bytes stay below its quantum, the grant does not move, even when other channels request.
- R4: When the arbiter re-arbitrates, it searches the channels starting at owner+1 and wraps from 3 to 0. The first requesting channel wins.
- R5: When the quantum runs out and no other channel requests, the owner keeps the grant, switch_o stays 0 and its byte count restarts from zero.
- R6: The byte count grows by beat_bytes_i only on cycles where beat_i is 1 and a grant is valid. The beat that reaches or crosses the quantum is counted in full, and the grant moves on the edge of that beat.
- R7: If the owner drops its request, the arbiter re-arbitrates on that edge. The grant moves to another requester, or gnt_valid_o falls if there is none.
- R8: A write with cfg_we_i=1 sets the quantum of channel cfg_idx_i to cfg_data_i from the next cycle on. A data value of 0 sets 1024.
- R9: With no request pending, gnt_valid_o is 0 and gnt_idx_o keeps the last owner. The next search starts after that owner.
- R10: switch_o is 1 for exactly the first cycle of a grant that goes to a different channel or that follows an idle cycle. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Pending-work request, one bit per channel |
| beat_i | input | 1 | The mover moved one beat for the owner this cycle |
| beat_bytes_i | input | 8 | Number of bytes in this beat |
| cfg_we_i | input | 1 | Quantum write enable |
| cfg_idx_i | input | 2 | Channel whose quantum is written |
| cfg_data_i | input | 16 | Quantum value in bytes (0 means 1024) |
| gnt_valid_o | output | 1 | A channel owns the mover |
| gnt_idx_o | output | 2 | Owning channel, or last owner when idle |
| switch_o | output | 1 | One-cycle pulse on a grant to a new channel |

## Verification
The stimulus walks through single requesters, pairs of requesters and all four requesting at once, with quanta of 4, 6, 4 and 1024 bytes. This tells a correct rotation apart from fixed priority, and a search from the owner apart from one that starts at channel 0. The beat sizes are picked so that the count lands exactly on a quantum, crosses it, or stops one byte short of it. This separates the ">=" comparison from an off-by-one. A byte count presented while beat_i is low, a drop by the owner partway through its quantum, and a quantum expiry with no competitor show whether idle cycles are ignored, whether early release works, and whether the arbiter stays put when no one else is waiting.

// File: rtl/qarb_pkg.sv
package qarb_pkg;
    localparam int QARB_CH    = 4;
    localparam int QARB_QW    = 16;
    localparam int QARB_BCW   = 8;
    localparam int QARB_DEF_Q = 1024;

    // Why the arbiter acts on a given edge
    typedef enum logic [1:0] {
        DEC_HOLD   = 2'd0,
        DEC_EXPIRE = 2'd1,
        DEC_DROP   = 2'd2,
        DEC_IDLE   = 2'd3
    } arb_cause_e;
endpackage

// File: rtl/qarb_quantum_regs.sv
module qarb_quantum_regs #(
    parameter int NUM_CH      = 4,
    parameter int QW          = 16,
    parameter int DEF_QUANTUM = 1024,
    localparam int IW         = $clog2(NUM_CH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [IW-1:0]              idx_i,
    input  logic [QW-1:0]              data_i,
    output logic [NUM_CH-1:0][QW-1:0]  quanta_o
);
    localparam logic [QW-1:0] DEF_Q = QW'(DEF_QUANTUM);

    logic [NUM_CH-1:0][QW-1:0] q_d, q_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            q_d[c] = q_q[c];
            if (we_i && (idx_i == IW'(c))) begin
                q_d[c] = (data_i == '0) ? DEF_Q : data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) q_q[c] <= DEF_Q;
        end else begin
            q_q <= q_d;
        end
    end

    assign quanta_o = q_q;

    logic past_ok_q;
    always_ff @(posedge clk) past_ok_q <= rst_n;

    // R8: a zero write turns into the default quantum
    assert_zero_write_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(we_i) && ($past(data_i) == '0) |-> quanta_o[$past(idx_i)] == DEF_Q);

    // R8: a nonzero write is stored exactly
    assert_write_stored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(we_i) && ($past(data_i) != '0) |-> quanta_o[$past(idx_i)] == $past(data_i));
endmodule

// File: rtl/qarb_rr_pick.sv
module qarb_rr_pick #(
    parameter int NUM_CH = 4,
    localparam int IW    = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [IW-1:0]     ptr_i,
    output logic              found_o,
    output logic [IW-1:0]     idx_o
);
    // Offsets 1..NUM_CH from the pointer; offset NUM_CH is the pointer itself.
    // Walk from the far end so the nearest requester is the one left standing.
    always_comb begin
        found_o = 1'b0;
        idx_o   = ptr_i;
        for (int k = NUM_CH; k >= 1; k--) begin
            int j;
            j = (int'(ptr_i) + k) % NUM_CH;
            if (req_i[j]) begin
                found_o = 1'b1;
                idx_o   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/qchan_arbiter.sv
module qchan_arbiter
    import qarb_pkg::*;
#(
    parameter int NUM_CH      = QARB_CH,
    parameter int QW          = QARB_QW,
    parameter int BCW         = QARB_BCW,
    parameter int DEF_QUANTUM = QARB_DEF_Q,
    localparam int IW         = $clog2(NUM_CH),
    localparam int CNT_W      = QW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              beat_i,
    input  logic [BCW-1:0]    beat_bytes_i,
    input  logic              cfg_we_i,
    input  logic [IW-1:0]     cfg_idx_i,
    input  logic [QW-1:0]     cfg_data_i,
    output logic              gnt_valid_o,
    output logic [IW-1:0]     gnt_idx_o,
    output logic              switch_o
);
    typedef struct packed {
        logic [IW-1:0]    owner;
        logic             valid;
        logic             sw;
        logic [CNT_W-1:0] used;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NUM_CH-1:0][QW-1:0] quanta;
    logic                      pick_found;
    logic [IW-1:0]             pick_idx;
    logic [CNT_W-1:0]          used_sum;
    arb_cause_e                cause;

    qarb_quantum_regs #(
        .NUM_CH      (NUM_CH),
        .QW          (QW),
        .DEF_QUANTUM (DEF_QUANTUM)
    ) i_quanta (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we_i),
        .idx_i    (cfg_idx_i),
        .data_i   (cfg_data_i),
        .quanta_o (quanta)
    );

    qarb_rr_pick #(.NUM_CH(NUM_CH)) i_pick (
        .req_i   (req_i),
        .ptr_i   (st_q.owner),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    always_comb begin
        st_d    = st_q;
        st_d.sw = 1'b0;

        used_sum = st_q.used;
        if (beat_i && st_q.valid) used_sum = st_q.used + CNT_W'(beat_bytes_i);

        if (!st_q.valid)                          cause = DEC_IDLE;
        else if (!req_i[st_q.owner])              cause = DEC_DROP;
        else if (used_sum >= CNT_W'(quanta[st_q.owner])) cause = DEC_EXPIRE;
        else                                      cause = DEC_HOLD;

        if (cause == DEC_HOLD) begin
            st_d.used = used_sum;
        end else begin
            st_d.used = '0;
            if (pick_found) begin
                st_d.valid = 1'b1;
                st_d.owner = pick_idx;
                st_d.sw    = !st_q.valid || (pick_idx != st_q.owner);
            end else begin
                st_d.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt_valid_o = st_q.valid;
    assign gnt_idx_o   = st_q.owner;
    assign switch_o    = st_q.sw;

    // ---------------- assertions ----------------
    logic              past_ok_q;
    logic [NUM_CH-1:0] req_seen_q;
    always_ff @(posedge clk) begin
        past_ok_q  <= rst_n;
        req_seen_q <= req_i;
    end

    assert_switch_needs_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        switch_o |-> gnt_valid_o);

    assert_switch_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && gnt_valid_o && $past(gnt_valid_o) && (gnt_idx_o != $past(gnt_idx_o)) |-> switch_o);

    assert_grant_was_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && switch_o |-> req_seen_q[gnt_idx_o]);

    assert_hold_until_quantum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cause == DEC_HOLD) |=> gnt_valid_o && $stable(gnt_idx_o) && !switch_o);

    assert_drop_rearbitrates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o && !req_i[gnt_idx_o] |=> !gnt_valid_o || switch_o);

    assert_idle_keeps_pointer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && !gnt_valid_o |-> gnt_idx_o == $past(gnt_idx_o));
endmodule

// File: tb/test_qchan_arbiter.sv
module test_qchan_arbiter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] req_i;
    logic       beat_i;
    logic [7:0] beat_bytes_i;
    logic       cfg_we_i;
    logic [1:0] cfg_idx_i;
    logic [15:0] cfg_data_i;
    logic       gnt_valid_o;
    logic [1:0] gnt_idx_o;
    logic       switch_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    qchan_arbiter i_qchan_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .beat_i(beat_i),
        .beat_bytes_i(beat_bytes_i), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
        .cfg_data_i(cfg_data_i), .gnt_valid_o(gnt_valid_o), .gnt_idx_o(gnt_idx_o),
        .switch_o(switch_o)
    );

    // {req, beat, bytes, exp_valid, exp_idx, exp_switch, requirement}
    typedef struct packed {
        logic [3:0] req;
        logic       beat;
        logic [7:0] bytes;
        logic       ev;
        logic [1:0] ei;
        logic       es;
        logic [7:0] rq;
    } vec_t;

    // Quanta programmed before the walk: ch0=4, ch1=6, ch2=4, ch3=0 (-> 1024)
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 1'b0, 8'd0,   1'b0, 2'd0, 1'b0, 8'd9 },  // R9 idle
        '{4'b0011, 1'b0, 8'd0,   1'b1, 2'd1, 1'b1, 8'd4 },  // R4 search starts at owner+1
        '{4'b0011, 1'b1, 8'd2,   1'b1, 2'd1, 1'b0, 8'd6 },  // R6 2 of 6
        '{4'b0011, 1'b1, 8'd3,   1'b1, 2'd1, 1'b0, 8'd3 },  // R3 5 of 6, ch0 waiting
        '{4'b0011, 1'b1, 8'd3,   1'b1, 2'd0, 1'b1, 8'd6 },  // R6 crossing beat, wrap to 0
        '{4'b0001, 1'b1, 8'd4,   1'b1, 2'd0, 1'b0, 8'd5 },  // R5 expire alone, stay
        '{4'b0001, 1'b1, 8'd3,   1'b1, 2'd0, 1'b0, 8'd5 },  // R5 counter restarted
        '{4'b0101, 1'b0, 8'd0,   1'b1, 2'd0, 1'b0, 8'd3 },  // R3 competitor waits
        '{4'b0101, 1'b1, 8'd1,   1'b1, 2'd2, 1'b1, 8'd4 },  // R4 skip ch1, take ch2
        '{4'b0101, 1'b0, 8'd9,   1'b1, 2'd2, 1'b0, 8'd6 },  // R6 bytes without beat ignored
        '{4'b0001, 1'b0, 8'd0,   1'b1, 2'd0, 1'b1, 8'd7 },  // R7 owner drops
        '{4'b0000, 1'b0, 8'd0,   1'b0, 2'd0, 1'b0, 8'd9 },  // R9 idle, keep pointer
        '{4'b1010, 1'b0, 8'd0,   1'b1, 2'd1, 1'b1, 8'd9 },  // R9 resume after last owner
        '{4'b1010, 1'b1, 8'd6,   1'b1, 2'd3, 1'b1, 8'd2 },  // R2 exact hit, to ch3
        '{4'b1010, 1'b1, 8'd255, 1'b1, 2'd3, 1'b0, 8'd8 },  // R8 zero write -> 1024
        '{4'b1010, 1'b1, 8'd255, 1'b1, 2'd3, 1'b0, 8'd8 },
        '{4'b1010, 1'b1, 8'd255, 1'b1, 2'd3, 1'b0, 8'd8 },
        '{4'b1010, 1'b1, 8'd255, 1'b1, 2'd3, 1'b0, 8'd8 },  // R8 1020 < 1024
        '{4'b1010, 1'b1, 8'd4,   1'b1, 2'd1, 1'b1, 8'd8 },  // R8 reaches 1024, wrap
        '{4'b0000, 1'b0, 8'd0,   1'b0, 2'd1, 1'b0, 8'd10},  // R10 no pulse when idle
        '{4'b1111, 1'b0, 8'd0,   1'b1, 2'd2, 1'b1, 8'd4 }   // R4 all request, after ch1
    };

    task automatic check(input int rq, input logic ev, input logic [1:0] ei, input logic es);
        n_cmp++;
        if (gnt_valid_o !== ev || gnt_idx_o !== ei || switch_o !== es) begin
            n_bad++;
            $display("FAIL R%0d: got valid=%0b idx=%0d sw=%0b, expected valid=%0b idx=%0d sw=%0b",
                     rq, gnt_valid_o, gnt_idx_o, switch_o, ev, ei, es);
        end
    endtask

    task automatic step(input logic [3:0] r, input logic b, input logic [7:0] n);
        @(negedge clk);
        req_i = r; beat_i = b; beat_bytes_i = n;
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_i = '0; beat_i = 1'b0; beat_bytes_i = '0;
        cfg_we_i = 1'b0; cfg_idx_i = '0; cfg_data_i = '0;
        repeat (2) @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [1:0] ch, input logic [15:0] v);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_idx_i = ch; cfg_data_i = v;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        check(1, 1'b0, 2'd0, 1'b0);              // R1 reset state

        cfg_write(2'd0, 16'd4);
        cfg_write(2'd1, 16'd6);
        cfg_write(2'd2, 16'd4);
        cfg_write(2'd3, 16'd0);                 // R8 zero means 1024

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].req, VECS[i].beat, VECS[i].bytes);
            check(int'(VECS[i].rq), VECS[i].ev, VECS[i].ei, VECS[i].es);
        end

        // R1: default quantum 1024 without any configuration
        do_reset();
        step(4'b0001, 1'b0, 8'd0);
        check(1, 1'b1, 2'd0, 1'b1);              // R10 pulse from idle
        for (int k = 0; k < 4; k++) step(4'b0001, 1'b1, 8'd255);
        step(4'b0011, 1'b1, 8'd3);              // 1023 bytes, still holding
        check(1, 1'b1, 2'd0, 1'b0);
        step(4'b0011, 1'b1, 8'd1);              // 1024 reached
        check(1, 1'b1, 2'd1, 1'b1);

        // R2 / R10: a single requester keeps the grant; no pulse after the first cycle
        step(4'b0010, 1'b0, 8'd0);
        check(10, 1'b1, 2'd1, 1'b0);

        // R8: rewrite ch1 to 2 bytes while it is granted
        cfg_write(2'd1, 16'd2);
        step(4'b0110, 1'b1, 8'd2);
        check(8, 1'b1, 2'd2, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule